// File: doc/BRIEF.md
# Core Power-Up Sequencer

This block takes one processor core out of power collapse. A single start pulse launches a fixed sequence. First the isolation clamps and both resets are asserted. Then the power gate is enabled, and the clamps and resets are let go one step at a time, with a settling interval between the steps. At the end of the sequence a powered-up flag is raised. While the core is off, every protective signal stays asserted.

The output clamp and the reset release cannot run ahead of the memory supply, because the order of the steps is fixed. Each settling interval is a parameter given in clock cycles, for example the clock frequency in MHz times two for a 2 µs wait. A busy output is high while the sequence is running, and a done output pulses for one cycle when the sequence finishes. Once the core is up, a new start runs the whole sequence again from the first step.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset, and until the first start, the outputs are in the safe off state: output clamp, memory clamp, core reset and power-on reset are 1; the memory head switch, powered-up, busy, done and the gate word are all 0.
- R2: A start sampled while idle makes the first step at that clock edge. In the first step the output clamp, memory clamp, core reset and power-on reset are 1, and the head switch, the gate word and powered-up are 0.
- R3: One cycle after the first step, the gate word takes the value with bit 0 (enable) set and the count field at bit 24 upward holding GATE_COUNT (default 16). All other bits are 0. The gate word keeps that value until the core is up.
- R4: The memory clamp falls exactly SETTLE_CYCLES cycles after the gate word is enabled.
- R5: The memory head switch turns on one cycle after the memory clamp falls.
- R6: The output clamp falls exactly SETTLE_CYCLES cycles after the head switch turns on.
- R7: The core reset and the power-on reset fall together, exactly SETTLE_CYCLES cycles after the output clamp falls.
- R8: Powered-up rises one cycle after the resets fall. Done is high for exactly that one cycle.
- R9: A start that arrives while busy is high has no effect on any output.
- R10: The control word has this bit layout: bit 0 output clamp, bit 1 memory clamp, bit 2 L1 reset disable (always 0), bit 3 memory head switch, bit 4 core reset, bit 5 power-on reset, bit 6 clock gate (always 0), bit 7 powered-up. Each bit equals the matching pin.
- R11: A start while the core is up (busy low) runs the sequence again from the first step, which clears powered-up and the head switch.
- R12: Busy is high from the first step until the cycle before powered-up rises, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the core is up |
| clamp_o | output | 1 | Output isolation clamp |
| mem_clamp_o | output | 1 | Memory clamp |
| mem_hs_o | output | 1 | Memory head-switch enable |
| core_rst_o | output | 1 | Core reset |
| por_rst_o | output | 1 | Core power-on reset |
| pwrd_up_o | output | 1 | Core powered-up flag |
| ctl_word_o | output | 8 | Packed control word (layout in R10) |
| gate_word_o | output | GATE_W | Power-gate control word (enable plus count field) |

## Verification
Take the clock edge that samples start as edge 0. The first step is visible right after edge 0. The gate word enables at edge 1. The memory clamp falls at edge S+1 and the head switch turns on at edge S+2. The output clamp falls at edge 2S+2 and the resets fall at edge 3S+2. Powered-up and done appear at edge 3S+3, and done clears at edge 3S+4. The bench keeps a cycle index from the start edge and samples every output on the falling clock edge after each rising edge. It compares each sample with values computed from these edge numbers. Starts injected while busy are checked on the next sample, to confirm that no output moved off the schedule.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_ASSERT,
    ST_GATE,
    ST_MEMREL,
    ST_HSON,
    ST_OCLREL,
    ST_RSTREL,
    ST_UP,
    ST_ON
  } pwr_state_e;

  // control word bit positions (consumed by neighbouring logic)
  localparam int unsigned CTL_W       = 8;
  localparam int unsigned CB_CLAMP    = 0;
  localparam int unsigned CB_MEMCLAMP = 1;
  localparam int unsigned CB_L1RSTDIS = 2;
  localparam int unsigned CB_MEMHS    = 3;
  localparam int unsigned CB_CORERST  = 4;
  localparam int unsigned CB_PORRST   = 5;
  localparam int unsigned CB_CLKGATE  = 6;
  localparam int unsigned CB_PWRDUP   = 7;

endpackage

// File: rtl/pwrup_settle_timer.sv
module pwrup_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = LOAD_VAL;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R4: the count never runs above the interval length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R4: a load always starts a full interval
  a_r4_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       settle_done_i,
  output pwr_state_e state_o,
  output logic       settle_load_o
);
  pwr_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d       = state_q;
    settle_load_o = 1'b0;
    unique case (state_q)
      ST_OFF, ST_ON: if (start_i) state_d = ST_ASSERT;
      ST_UP:         state_d = start_i ? ST_ASSERT : ST_ON;
      ST_ASSERT: begin
        state_d       = ST_GATE;
        settle_load_o = 1'b1;
      end
      ST_GATE:       if (settle_done_i) state_d = ST_MEMREL;
      ST_MEMREL: begin
        state_d       = ST_HSON;
        settle_load_o = 1'b1;
      end
      ST_HSON: begin
        if (settle_done_i) begin
          state_d       = ST_OCLREL;
          settle_load_o = 1'b1;
        end
      end
      ST_OCLREL:     if (settle_done_i) state_d = ST_RSTREL;
      ST_RSTREL:     state_d = ST_UP;
      default:       state_d = ST_OFF;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_OFF;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: a wait step is held until its interval expires
  a_r4_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATE && !settle_done_i) |=> (state_q == ST_GATE));

  // R9: a start while mid-sequence never returns to the first step
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_HSON) |=> (state_q != ST_ASSERT));

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 100,
  parameter int unsigned GATE_W        = 32,
  parameter int unsigned CNT_LSB       = 24,
  parameter int unsigned GATE_COUNT    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              clamp_o,
  output logic              mem_clamp_o,
  output logic              mem_hs_o,
  output logic              core_rst_o,
  output logic              por_rst_o,
  output logic              pwrd_up_o,
  output logic [CTL_W-1:0]  ctl_word_o,
  output logic [GATE_W-1:0] gate_word_o
);
  localparam logic [GATE_W-1:0] GATE_ON =
    (GATE_W'(GATE_COUNT) << CNT_LSB) | GATE_W'(1);

  pwr_state_e state;
  logic       settle_load, settle_done, gate_en;

  pwrup_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .settle_done_i (settle_done),
    .state_o       (state),
    .settle_load_o (settle_load)
  );

  pwrup_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (settle_load),
    .expired_o (settle_done)
  );

  // Moore decode: every output follows the registered step
  always_comb begin
    clamp_o     = 1'b1;
    mem_clamp_o = 1'b1;
    mem_hs_o    = 1'b0;
    core_rst_o  = 1'b1;
    por_rst_o   = 1'b1;
    pwrd_up_o   = 1'b0;
    gate_en     = 1'b0;
    busy_o      = 1'b0;
    done_o      = 1'b0;
    unique case (state)
      ST_OFF: ;
      ST_ASSERT: busy_o = 1'b1;
      ST_GATE: begin
        busy_o = 1'b1; gate_en = 1'b1;
      end
      ST_MEMREL: begin
        busy_o = 1'b1; gate_en = 1'b1; mem_clamp_o = 1'b0;
      end
      ST_HSON: begin
        busy_o = 1'b1; gate_en = 1'b1; mem_clamp_o = 1'b0; mem_hs_o = 1'b1;
      end
      ST_OCLREL: begin
        busy_o = 1'b1; gate_en = 1'b1; mem_clamp_o = 1'b0; mem_hs_o = 1'b1;
        clamp_o = 1'b0;
      end
      ST_RSTREL: begin
        busy_o = 1'b1; gate_en = 1'b1; mem_clamp_o = 1'b0; mem_hs_o = 1'b1;
        clamp_o = 1'b0; core_rst_o = 1'b0; por_rst_o = 1'b0;
      end
      ST_UP, ST_ON: begin
        gate_en = 1'b1; mem_clamp_o = 1'b0; mem_hs_o = 1'b1;
        clamp_o = 1'b0; core_rst_o = 1'b0; por_rst_o = 1'b0;
        pwrd_up_o = 1'b1;
        done_o = (state == ST_UP);
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl_word_o              = '0;
    ctl_word_o[CB_CLAMP]    = clamp_o;
    ctl_word_o[CB_MEMCLAMP] = mem_clamp_o;
    ctl_word_o[CB_L1RSTDIS] = 1'b0;
    ctl_word_o[CB_MEMHS]    = mem_hs_o;
    ctl_word_o[CB_CORERST]  = core_rst_o;
    ctl_word_o[CB_PORRST]   = por_rst_o;
    ctl_word_o[CB_CLKGATE]  = 1'b0;
    ctl_word_o[CB_PWRDUP]   = pwrd_up_o;
  end

  assign gate_word_o = gate_en ? GATE_ON : '0;

  // R3: the memory clamp never drops without the power gate on
  a_r3_gate_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_clamp_o) |-> gate_word_o[0]);

  // R5: head switch follows the memory clamp release by one cycle
  a_r5_hs_after_memrel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_clamp_o) |=> $rose(mem_hs_o));

  // R6: output clamp released only with the head switch already on
  a_r6_clamp_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_o) |-> (mem_hs_o && $past(mem_hs_o)));

  // R7: both resets leave together
  a_r7_resets_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> $fell(por_rst_o));

  // R8: powered-up comes with done and ends busy
  a_r8_done_with_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrd_up_o) |-> (done_o && !busy_o));

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a busy start cannot re-clamp a released memory
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !mem_clamp_o) |=> !mem_clamp_o);

endmodule

// File: tb/core_pwrup_seq_test.sv
module core_pwrup_seq_test;
  localparam int S = 5;

  logic        clk, rst_n, start_i;
  logic        busy_o, done_o, clamp_o, mem_clamp_o, mem_hs_o;
  logic        core_rst_o, por_rst_o, pwrd_up_o;
  logic [7:0]  ctl_word_o;
  logic [31:0] gate_word_o;

  int n_chk  = 0;
  int n_fail = 0;

  core_pwrup_seq #(.SETTLE_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .clamp_o(clamp_o),
    .mem_clamp_o(mem_clamp_o), .mem_hs_o(mem_hs_o),
    .core_rst_o(core_rst_o), .por_rst_o(por_rst_o),
    .pwrd_up_o(pwrd_up_o), .ctl_word_o(ctl_word_o),
    .gate_word_o(gate_word_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected values from the step schedule; t counts edges after the start edge
  function automatic logic [7:0] exp_ctl(input bit run, input int t);
    logic clamp, mc, hs, rst, up;
    if (!run) begin
      clamp = 1; mc = 1; hs = 0; rst = 1; up = 0;
    end else begin
      clamp = (t <= 2*S + 1);
      mc    = (t <= S);
      hs    = (t >= S + 2);
      rst   = (t <= 3*S + 1);
      up    = (t >= 3*S + 3);
    end
    return {up, 1'b0, rst, rst, hs, 1'b0, mc, clamp};
  endfunction

  function automatic logic [31:0] exp_gate(input bit run, input int t);
    return (run && t >= 1) ? ((32'd16 << 24) | 32'd1) : 32'd0;
  endfunction

  function automatic logic exp_busy(input bit run, input int t);
    return run && (t <= 3*S + 2);
  endfunction

  function automatic logic exp_done(input bit run, input int t);
    return run && (t == 3*S + 3);
  endfunction

  function automatic logic [7:0] pins();
    return {pwrd_up_o, 1'b0, por_rst_o, core_rst_o, mem_hs_o, 1'b0, mem_clamp_o, clamp_o};
  endfunction

  task automatic check_all(input bit run, input int t);
    chk("R10 control word layout", ctl_word_o, exp_ctl(run, t));
    chk("R10 pins match word", pins(), exp_ctl(run, t));
    chk("R3 gate word", gate_word_o, exp_gate(run, t));
    chk("R12 busy", busy_o, exp_busy(run, t));
    chk("R8 done", done_o, exp_done(run, t));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unused;
    bit injected;
    unused  = $urandom(32'd7);
    rst_n   = 1'b0;
    start_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    for (int k = 0; k < 3; k++) begin
      check_all(1'b0, 0);
      chk("R1 safe off state", {clamp_o, mem_clamp_o, core_rst_o, por_rst_o,
                                mem_hs_o, pwrd_up_o, busy_o, done_o}, 8'hF0);
      @(negedge clk);
    end
    repeat (1 + $urandom % 4) @(negedge clk);

    for (int seq = 0; seq < 6; seq++) begin
      int last_t;
      start_i = 1'b1;
      @(negedge clk);
      injected = 1'b0;
      last_t   = 3*S + 4 + int'($urandom % 4);
      for (int t = 0; t <= last_t; t++) begin
        start_i = 1'b0;
        check_all(1'b1, t);
        if (t == 0) begin
          chk("R2 first step", {clamp_o, mem_clamp_o, core_rst_o, por_rst_o,
                                mem_hs_o, pwrd_up_o, gate_word_o[0]}, 7'b1111000);
          if (seq > 0) chk("R11 restart clears powered-up", pwrd_up_o, 1'b0);
        end
        if (t == S)         chk("R4 memory clamp still held", mem_clamp_o, 1'b1);
        if (t == S + 1)     chk("R4 memory clamp released", mem_clamp_o, 1'b0);
        if (t == S + 1)     chk("R5 head switch not yet on", mem_hs_o, 1'b0);
        if (t == S + 2)     chk("R5 head switch on", mem_hs_o, 1'b1);
        if (t == 2*S + 1)   chk("R6 output clamp still held", clamp_o, 1'b1);
        if (t == 2*S + 2)   chk("R6 output clamp released", clamp_o, 1'b0);
        if (t == 3*S + 1)   chk("R7 resets still held", {core_rst_o, por_rst_o}, 2'b11);
        if (t == 3*S + 2)   chk("R7 resets released together", {core_rst_o, por_rst_o}, 2'b00);
        if (t == 3*S + 3)   chk("R8 powered-up", pwrd_up_o, 1'b1);
        if (injected)       chk("R9 busy start ignored", ctl_word_o, exp_ctl(1'b1, t));
        injected = 1'b0;
        if (t <= 3*S + 1 && ($urandom % 3) == 0) begin
          start_i  = 1'b1;
          injected = 1'b1;
        end
        @(negedge clk);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule